// File: doc/BRIEF.md
# Burst Transmit Data Interface Controller

This controller runs one transmit burst of a baseband modulator from a single master clock. An external processor raises a burst-enable line. The controller drops its ready flag and, after a short fixed lead-in, starts a bit clock. The processor uses that bit clock to shift serial transmit data. The controller takes each bit when the bit clock falls and pairs the bits into two-bit symbols. Each symbol is issued as an I/Q level pair with a one-cycle valid strobe. The first symbol of a burst carries a ramp-up flag, and the last symbol carries a ramp-down flag.

When burst-enable is removed, the controller finishes the symbol it is receiving and then drains a fixed number of further symbols. It completes the final bit-clock cycle and returns to ready. Two mode pins choose normal operation or a frequency-test mode. In frequency-test mode the I/Q levels are fixed, but the ramp flags still mark the start and end of the burst. A power input puts the block into a sleep state in which the bit clock stops and an output-disable flag is raised.

Top module: `burst_tx_ctrl`

## Requirements
- R1: After reset, ready is high, and bit_clk, sym_valid, ramp_up, ramp_down and out_disable are all low.
- R2: When burst_en is sampled high in the idle state with pwr_on high, ready goes low on that same master-clock edge.
- R3: bit_clk first goes high on the LEAD_CYC-th edge (default 2) after the edge that dropped ready. While running, it is high for BCLK_DIV/2 master cycles and low for BCLK_DIV/2. At every other time it is held low.
- R4: tx_bit is captured on the master edge at which bit_clk falls. The first bit of a pair sets I and the second sets Q. sym_valid pulses for one cycle after the second capture. Bit 0 maps to +FS and bit 1 maps to −FS, where FS = 2^(LVL_W−1)−1.
- R5: After burst_en is seen low, the symbol in progress is completed and exactly DRAIN_SYMS (default 4) further symbols follow. No further symbols are issued after that.
- R6: ready returns high BCLK_DIV/2 master cycles after the last sym_valid, at the end of that final bit-clock cycle. bit_clk stays low from then on.
- R7: ramp_up is high together with the first sym_valid of a burst, and ramp_down is high together with the last. Each is one cycle wide.
- R8: The mode pins are decoded as follows: {mode_a, mode_b} = 01 selects frequency test; 00, 10 and 11 select normal operation.
- R9: In frequency-test mode every symbol has sym_i = 0 and sym_q = +FS, and ramp_up and ramp_down behave as in R7.
- R10: burst_en going high during the drain has no effect. The symbol count stays as in R5, and ready returns high on schedule.
- R11: pwr_on low forces sleep on the next edge: out_disable goes high, and ready and bit_clk go low and stay low. When pwr_on returns high, the block is idle with ready high after one edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| burst_en | input | 1 | Burst enable from the processor |
| pwr_on | input | 1 | Low requests sleep |
| mode_a | input | 1 | Mode select pin A |
| mode_b | input | 1 | Mode select pin B |
| tx_bit | input | 1 | Serial transmit data |
| ready | output | 1 | Idle, waiting for a burst |
| bit_clk | output | 1 | Generated bit clock, low when inactive |
| sym_valid | output | 1 | One-cycle strobe for a new symbol |
| sym_i | output | LVL_W | Signed I level |
| sym_q | output | LVL_W | Signed Q level |
| ramp_up | output | 1 | Marks the first symbol of a burst |
| ramp_down | output | 1 | Marks the last symbol of a burst |
| out_disable | output | 1 | High-impedance request while asleep |

## Verification
The bench builds the block with BCLK_DIV = 4 and LVL_W = 4, and leaves LEAD_CYC = 2 and DRAIN_SYMS = 4 at their defaults. The short bit clock makes each burst only a few dozen master cycles long. This brings several complete bursts, one in each mode-pin combination, a re-enable inside the drain and a sleep cut within a short run. A full scale of 7 keeps the ±FS and zero levels easy to tell apart when values are compared.

// File: rtl/btx_pkg.sv
`timescale 1ns/1ps
package btx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_RUN,
    ST_DRAIN,
    ST_TAIL,
    ST_SLEEP
  } btx_state_e;

  typedef enum logic {
    MD_NORMAL,
    MD_FTEST
  } btx_mode_e;

  // Only the pattern A low / B high selects the fixed-level test mode.
  function automatic btx_mode_e decode_mode(input logic sel_a, input logic sel_b);
    return (!sel_a && sel_b) ? MD_FTEST : MD_NORMAL;
  endfunction

endpackage

// File: rtl/btx_bitclk.sv
`timescale 1ns/1ps
module btx_bitclk #(
  parameter int BCLK_DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_nxt,
  output logic bclk,
  output logic fall_evt,
  output logic end_evt
);
  localparam int HALF = BCLK_DIV / 2;
  localparam int CW   = (BCLK_DIV > 2) ? $clog2(BCLK_DIV) : 1;

  logic [CW-1:0] cnt, cnt_nx;
  logic          act;

  always_comb begin
    cnt_nx = (cnt == CW'(BCLK_DIV - 1)) ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      act  <= 1'b0;
      bclk <= 1'b0;
    end else if (!run_nxt) begin
      cnt  <= '0;
      act  <= 1'b0;
      bclk <= 1'b0;
    end else if (!act) begin
      act  <= 1'b1;
      cnt  <= '0;
      bclk <= 1'b1;
    end else begin
      cnt  <= cnt_nx;
      bclk <= (cnt_nx < CW'(HALF));
    end
  end

  assign fall_evt = act && (cnt == CW'(HALF - 1));
  assign end_evt  = act && (cnt == CW'(BCLK_DIV - 1));

  assert_bclk_parked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !run_nxt |=> !bclk);
  assert_fall_from_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fall_evt |-> bclk);

endmodule

// File: rtl/btx_symbuild.sv
`timescale 1ns/1ps
module btx_symbuild #(
  parameter int LVL_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    active,
  input  logic                    fall_evt,
  input  logic                    tx_bit,
  input  logic                    ftest,
  input  logic                    first_sym,
  input  logic                    last_sym,
  output logic                    sym_done,
  output logic                    sym_valid,
  output logic signed [LVL_W-1:0] sym_i,
  output logic signed [LVL_W-1:0] sym_q,
  output logic                    ramp_up,
  output logic                    ramp_down
);
  localparam logic signed [LVL_W-1:0] FS = LVL_W'((1 << (LVL_W - 1)) - 1);

  function automatic logic signed [LVL_W-1:0] bit_level(input logic b);
    return b ? -FS : FS;
  endfunction

  logic                    bit_ph;
  logic                    i_bit;
  logic signed [LVL_W-1:0] nx_i, nx_q;

  assign sym_done = fall_evt && bit_ph;

  always_comb begin
    nx_i = ftest ? '0 : bit_level(i_bit);
    nx_q = ftest ? FS : bit_level(tx_bit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_ph    <= 1'b0;
      i_bit     <= 1'b0;
      sym_valid <= 1'b0;
      sym_i     <= '0;
      sym_q     <= '0;
      ramp_up   <= 1'b0;
      ramp_down <= 1'b0;
    end else begin
      sym_valid <= 1'b0;
      ramp_up   <= 1'b0;
      ramp_down <= 1'b0;
      if (!active) begin
        bit_ph <= 1'b0;
      end else if (fall_evt) begin
        if (!bit_ph) begin
          i_bit  <= tx_bit;
          bit_ph <= 1'b1;
        end else begin
          bit_ph    <= 1'b0;
          sym_valid <= 1'b1;
          sym_i     <= nx_i;
          sym_q     <= nx_q;
          ramp_up   <= first_sym;
          ramp_down <= last_sym;
        end
      end
    end
  end

  assert_valid_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid |=> !sym_valid);
  assert_ramp_on_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp_up || ramp_down) |-> sym_valid);
  assert_ramp_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ramp_up, ramp_down}));

endmodule

// File: rtl/btx_seq.sv
`timescale 1ns/1ps
module btx_seq
  import btx_pkg::*;
#(
  parameter int LEAD_CYC   = 2,
  parameter int DRAIN_SYMS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic burst_en,
  input  logic pwr_on,
  input  logic sym_done,
  input  logic end_evt,
  output logic ready,
  output logic out_disable,
  output logic run_nxt,
  output logic active,
  output logic first_sym,
  output logic last_sym
);
  localparam int LCW = $clog2(LEAD_CYC + 1);
  localparam int DCW = $clog2(DRAIN_SYMS + 1);

  btx_state_e     state, state_nx;
  logic [LCW-1:0] lead_cnt;
  logic [DCW-1:0] drain_left;
  logic           stop_seen;

  always_comb begin
    state_nx = state;
    if (!pwr_on) begin
      state_nx = ST_SLEEP;
    end else begin
      case (state)
        ST_SLEEP: state_nx = ST_IDLE;
        ST_IDLE:  if (burst_en) state_nx = ST_LEAD;
        ST_LEAD:  if (lead_cnt == LCW'(LEAD_CYC - 1)) state_nx = ST_RUN;
        ST_RUN:   if (sym_done && (stop_seen || !burst_en)) state_nx = ST_DRAIN;
        ST_DRAIN: if (sym_done && drain_left == DCW'(1)) state_nx = ST_TAIL;
        ST_TAIL:  if (end_evt) state_nx = ST_IDLE;
        default:  state_nx = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      lead_cnt   <= '0;
      drain_left <= '0;
      stop_seen  <= 1'b0;
      first_sym  <= 1'b0;
    end else begin
      state <= state_nx;
      if (state == ST_IDLE && state_nx == ST_LEAD) begin
        lead_cnt  <= '0;
        stop_seen <= 1'b0;
        first_sym <= 1'b1;
      end else begin
        if (state == ST_LEAD) lead_cnt <= lead_cnt + 1'b1;
        if (state == ST_RUN && !burst_en) stop_seen <= 1'b1;
        if (sym_done) first_sym <= 1'b0;
      end
      if (state == ST_RUN && state_nx == ST_DRAIN) drain_left <= DCW'(DRAIN_SYMS);
      else if (state == ST_DRAIN && sym_done) drain_left <= drain_left - 1'b1;
    end
  end

  assign ready       = (state == ST_IDLE);
  assign out_disable = (state == ST_SLEEP);
  assign active      = (state == ST_RUN) || (state == ST_DRAIN) || (state == ST_TAIL);
  assign run_nxt     = (state_nx == ST_RUN) || (state_nx == ST_DRAIN) || (state_nx == ST_TAIL);
  assign last_sym    = (state == ST_DRAIN) && (drain_left == DCW'(1));

  assert_ready_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && burst_en && pwr_on) |=> !ready);
  assert_sleep_entry_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_on |=> (out_disable && !ready));
  assert_drain_blind_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DRAIN && !sym_done && pwr_on) |=> (state == ST_DRAIN));

endmodule

// File: rtl/burst_tx_ctrl.sv
`timescale 1ns/1ps
module burst_tx_ctrl
  import btx_pkg::*;
#(
  parameter int BCLK_DIV   = 8,
  parameter int LEAD_CYC   = 2,
  parameter int DRAIN_SYMS = 4,
  parameter int LVL_W      = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    burst_en,
  input  logic                    pwr_on,
  input  logic                    mode_a,
  input  logic                    mode_b,
  input  logic                    tx_bit,
  output logic                    ready,
  output logic                    bit_clk,
  output logic                    sym_valid,
  output logic signed [LVL_W-1:0] sym_i,
  output logic signed [LVL_W-1:0] sym_q,
  output logic                    ramp_up,
  output logic                    ramp_down,
  output logic                    out_disable
);
  // Named internal events shared between the sub-blocks.
  logic      run_nxt, active, fall_evt, end_evt, sym_done;
  logic      first_sym, last_sym, ftest;
  btx_mode_e mode_sel;

  assign mode_sel = decode_mode(mode_a, mode_b);
  assign ftest    = (mode_sel == MD_FTEST);

  btx_seq #(.LEAD_CYC(LEAD_CYC), .DRAIN_SYMS(DRAIN_SYMS)) u_seq (
    .clk(clk), .rst_n(rst_n), .burst_en(burst_en), .pwr_on(pwr_on),
    .sym_done(sym_done), .end_evt(end_evt), .ready(ready),
    .out_disable(out_disable), .run_nxt(run_nxt), .active(active),
    .first_sym(first_sym), .last_sym(last_sym)
  );

  btx_bitclk #(.BCLK_DIV(BCLK_DIV)) u_bclk (
    .clk(clk), .rst_n(rst_n), .run_nxt(run_nxt), .bclk(bit_clk),
    .fall_evt(fall_evt), .end_evt(end_evt)
  );

  btx_symbuild #(.LVL_W(LVL_W)) u_sym (
    .clk(clk), .rst_n(rst_n), .active(active), .fall_evt(fall_evt),
    .tx_bit(tx_bit), .ftest(ftest), .first_sym(first_sym), .last_sym(last_sym),
    .sym_done(sym_done), .sym_valid(sym_valid), .sym_i(sym_i), .sym_q(sym_q),
    .ramp_up(ramp_up), .ramp_down(ramp_down)
  );

  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (!bit_clk && !sym_valid));
  assert_sleep_no_clock_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_disable |-> !bit_clk);

endmodule

// File: tb/sim_burst_tx_ctrl.sv
`timescale 1ns/1ps
module sim_burst_tx_ctrl;
  localparam int DIV  = 4;
  localparam int HALF = DIV / 2;
  localparam int DR   = 4;
  localparam int W    = 4;
  localparam int FSV  = 7;

  typedef struct packed {
    logic signed [W-1:0] i;
    logic signed [W-1:0] q;
    logic                ru;
    logic                rd;
  } exp_t;

  logic clk = 0, rst_n = 0, burst_en = 0, pwr_on = 1, mode_a = 0, mode_b = 0, tx_bit = 0;
  logic ready, bit_clk, sym_valid, ramp_up, ramp_down, out_disable;
  logic signed [W-1:0] sym_i, sym_q;

  int   checks = 0, errors = 0, n_sym = 0, hi_cnt = 0;
  bit   sb_on = 0, pw_on = 0, done = 0;
  logic [7:0] lfsr = 8'hA5;
  exp_t exp_q[$];
  logic bit_q[$];

  burst_tx_ctrl #(.BCLK_DIV(DIV), .LVL_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .burst_en(burst_en), .pwr_on(pwr_on),
    .mode_a(mode_a), .mode_b(mode_b), .tx_bit(tx_bit), .ready(ready),
    .bit_clk(bit_clk), .sym_valid(sym_valid), .sym_i(sym_i), .sym_q(sym_q),
    .ramp_up(ramp_up), .ramp_down(ramp_down), .out_disable(out_disable)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int level(input logic b);
    return FSV * (1 - 2 * int'(b));
  endfunction

  // Data source: new bit shortly after each rising bit clock.
  always @(posedge bit_clk) begin
    #1;
    tx_bit = (bit_q.size() != 0) ? bit_q.pop_front() : 1'b0;
  end

  // Monitor: compares each strobed symbol with the scoreboard head.
  always @(negedge clk) begin
    if (sb_on && sym_valid) begin
      n_sym++;
      if (exp_q.size() == 0) begin
        chk(0, "R5", "symbol beyond drain", n_sym, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(sym_i == e.i, "R4/R9", "sym_i", int'(sym_i), int'(e.i));
        chk(sym_q == e.q, "R4/R9", "sym_q", int'(sym_q), int'(e.q));
        chk(ramp_up == e.ru && ramp_down == e.rd, "R7", "ramp flags {up,down}",
            int'({ramp_up, ramp_down}), int'({e.ru, e.rd}));
      end
    end
  end

  // Bit-clock high width, R3.
  always @(negedge clk) begin
    if (pw_on) begin
      if (bit_clk) hi_cnt++;
      else if (hi_cnt != 0) begin
        chk(hi_cnt == HALF, "R3", "bit_clk high width", hi_cnt, HALF);
        hi_cnt = 0;
      end
    end else hi_cnt = 0;
  end

  // Driver: plans the bit stream and the expected symbols, then runs a burst.
  task automatic run_burst(input int k, input logic ma, input logic mb, input bit ft, input bit reenter);
    int s = k + 1 + DR;
    logic b0, b1;
    mode_a = ma; mode_b = mb;
    for (int j = 0; j < s; j++) begin
      exp_t e;
      b0 = lfsr[0]; lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      b1 = lfsr[0]; lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      bit_q.push_back(b0); bit_q.push_back(b1);
      e.i  = ft ? W'(0) : W'(level(b0));
      e.q  = ft ? W'(FSV) : W'(level(b1));
      e.ru = (j == 0);
      e.rd = (j == s - 1);
      exp_q.push_back(e);
    end
    bit_q.push_back(1'b0); bit_q.push_back(1'b0);
    n_sym = 0; sb_on = 1; pw_on = 1;
    @(negedge clk); burst_en = 1;
    @(negedge clk);
    chk(ready == 0, "R2", "ready one edge after burst_en", int'(ready), 0);
    chk(bit_clk == 0, "R3", "bit_clk in lead-in", int'(bit_clk), 0);
    @(negedge clk);
    chk(bit_clk == 0, "R3", "bit_clk one edge after ready fall", int'(bit_clk), 0);
    @(negedge clk);
    chk(bit_clk == 1, "R3", "bit_clk two edges after ready fall", int'(bit_clk), 1);
    while (n_sym < k) begin @(negedge clk); #2; end
    burst_en = 0;
    if (reenter) begin
      while (n_sym < k + 2) begin @(negedge clk); #2; end
      burst_en = 1;
      repeat (3) @(negedge clk);
      #2 burst_en = 0;
    end
    while (n_sym < s) begin @(negedge clk); #2; end
    chk(ready == 0, "R6", "ready at last symbol", int'(ready), 0);
    repeat (HALF - 1) @(negedge clk);
    chk(ready == 0, "R6", "ready before end of final bit clock", int'(ready), 0);
    @(negedge clk);
    chk(ready == 1, "R6", "ready after final bit clock", int'(ready), 1);
    chk(bit_clk == 0, "R6", "bit_clk parked", int'(bit_clk), 0);
    repeat (3 * DIV) @(negedge clk);
    chk(n_sym == s, reenter ? "R10" : "R5", "symbols in burst", n_sym, s);
    chk(exp_q.size() == 0, "R5", "expected symbols left", exp_q.size(), 0);
    chk(ready == 1, "R10", "ready stays high after burst", int'(ready), 1);
    sb_on = 0; pw_on = 0;
    bit_q.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(ready == 1, "R1", "reset ready", int'(ready), 1);
    chk({bit_clk, sym_valid, ramp_up, ramp_down, out_disable} == 5'b0, "R1", "reset outputs",
        int'({bit_clk, sym_valid, ramp_up, ramp_down, out_disable}), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(ready == 1, "R1", "idle after reset release", int'(ready), 1);

    run_burst(3, 1'b0, 1'b0, 1'b0, 1'b0);   // normal, R4 R5 R6 R7
    run_burst(1, 1'b1, 1'b1, 1'b0, 1'b0);   // reserved 11 acts normal, R8
    run_burst(2, 1'b0, 1'b1, 1'b1, 1'b0);   // frequency test, R8 R9
    run_burst(2, 1'b1, 1'b0, 1'b0, 1'b1);   // reserved 10, re-enable in drain, R10

    // Sleep cut during a burst, R11.
    mode_a = 0; mode_b = 0;
    @(negedge clk); burst_en = 1;
    repeat (8) @(negedge clk);
    pwr_on = 0;
    @(negedge clk);
    chk(out_disable == 1, "R11", "out_disable in sleep", int'(out_disable), 1);
    chk(ready == 0, "R11", "ready in sleep", int'(ready), 0);
    chk(bit_clk == 0, "R11", "bit_clk in sleep", int'(bit_clk), 0);
    begin
      int hi = 0;
      for (int c = 0; c < 12; c++) begin
        @(negedge clk);
        if (bit_clk || ready || !out_disable) hi++;
      end
      chk(hi == 0, "R11", "cycles leaving sleep outputs", hi, 0);
    end
    burst_en = 0; pwr_on = 1;
    @(negedge clk);
    chk(ready == 1 && out_disable == 0, "R11", "idle after wake {ready,dis}",
        int'({ready, out_disable}), 2);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule